// File: doc/BRIEF.md
# Carry-Arbitration Adder ALU

This block is the arithmetic and logic unit of a 32-bit datapath, built with no registers. Two operands come in, and either operand can be complemented on the way in. The conditioned operands then feed two units at the same time. One is an adder whose carries come from a parallel-prefix tree. The other is a separate bitwise logic unit. An output multiplexer chooses which of the two results goes out, and four condition flags are produced beside the result.

The adder does not use a propagate/generate pair at each bit. It records two facts per bit: the carry-out if the carry into that bit were one, and the carry-out if it were zero. Adjacent groups merge through an associative operator, so all prefixes settle after log2 of the width levels. Each prefix pair then yields two bits at once: one bit of the sum and the matching bit of the sum plus one. The true carry-in arrives late and only picks between those two results.

The block has no clock and no handshake. A datapath controller drives the operands, the operation code and the current carry and overflow flags, and it takes the result in the same cycle.

Top module: `alu_carry_arb`

## Requirements
- R1: With op_i=0 (add) the result is a_i+b_i modulo 2^32 and C is bit 32 of the unsigned sum. With op_i=1 (add with carry) the value c_i is also added.
- R2: With op_i=2 (subtract) the result is a_i-b_i, computed as a_i+~b_i+1. With op_i=3 (subtract with carry) it is a_i+~b_i+c_i. With op_i=4 (reverse subtract) it is b_i-a_i, computed as ~a_i+b_i+1. In each case C is bit 32 of that unsigned sum.
- R3: The carry-out is correct when a carry has to travel across the whole width. Examples are 0xFFFFFFFF+1 and 0xFFFFFFFF+0 with carry-in 1, which both give result 0 and C=1.
- R4: For the codes 0 to 4, V is 1 exactly when the two operands actually presented to the adder (after complementing) have the same bit 31 and the result's bit 31 differs from it.
- R5: For every code, N equals bit 31 of the result and Z is 1 exactly when all 32 result bits are 0.
- R6: op_i=5 gives a_i AND b_i, 6 gives a_i OR b_i, 7 gives a_i XOR b_i and 8 gives a_i AND NOT b_i.
- R7: op_i=9 gives b_i, op_i=10 gives NOT b_i, and the unused codes 11 to 15 behave like code 9.
- R8: For every code from 5 to 15, C equals the input c_i and V equals the input v_i. Neither operand affects those two flags.
- R9: For add with carry, the result with c_i=1 is exactly one more (modulo 2^32) than the result with c_i=0 for the same operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 4 | Operation code (values listed in R1, R2, R6 and R7) |
| c_i | input | 1 | Current carry flag: carry-in for codes 1 and 3, passed to C for logic codes |
| v_i | input | 1 | Current overflow flag, passed to V for logic codes |
| res_o | output | 32 | Selected result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag |

## Verification
Every output is combinational, so each result and each flag is due in the same cycle as the stimulus, with no register on the path. The bench changes all inputs together on a falling clock edge. It samples the result and the four flags one time unit later, after the logic has settled and well before the next rising edge, so the sampling point never falls at a clock edge. Expected values come from a plain reference that uses wide integer addition and bitwise operators.

// File: rtl/alu_carry_arb_pkg.sv
package alu_carry_arb_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_RSB = 4'd4,
    OP_AND = 4'd5,
    OP_ORR = 4'd6,
    OP_EOR = 4'd7,
    OP_BIC = 4'd8,
    OP_MOV = 4'd9,
    OP_MVN = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    LF_AND   = 2'd0,
    LF_ORR   = 2'd1,
    LF_EOR   = 2'd2,
    LF_PASSB = 2'd3
  } logic_fn_e;

  typedef enum logic [1:0] {
    CI_ZERO = 2'd0,
    CI_ONE  = 2'd1,
    CI_FLAG = 2'd2
  } cin_sel_e;

  typedef struct packed {
    logic      inv_a;
    logic      inv_b;
    cin_sel_e  cin_sel;
    logic      use_logic;
    logic_fn_e lfn;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_carry_arb_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '{inv_a: 1'b0, inv_b: 1'b0, cin_sel: CI_ZERO,
               use_logic: 1'b1, lfn: LF_PASSB};
    case (op_i)
      OP_ADD: begin ctrl_o.use_logic = 1'b0; end
      OP_ADC: begin ctrl_o.use_logic = 1'b0; ctrl_o.cin_sel = CI_FLAG; end
      OP_SUB: begin ctrl_o.use_logic = 1'b0; ctrl_o.inv_b = 1'b1; ctrl_o.cin_sel = CI_ONE; end
      OP_SBC: begin ctrl_o.use_logic = 1'b0; ctrl_o.inv_b = 1'b1; ctrl_o.cin_sel = CI_FLAG; end
      OP_RSB: begin ctrl_o.use_logic = 1'b0; ctrl_o.inv_a = 1'b1; ctrl_o.cin_sel = CI_ONE; end
      OP_AND: ctrl_o.lfn = LF_AND;
      OP_ORR: ctrl_o.lfn = LF_ORR;
      OP_EOR: ctrl_o.lfn = LF_EOR;
      OP_BIC: begin ctrl_o.lfn = LF_AND; ctrl_o.inv_b = 1'b1; end
      OP_MVN: begin ctrl_o.lfn = LF_PASSB; ctrl_o.inv_b = 1'b1; end
      default: ctrl_o.lfn = LF_PASSB;
    endcase
  end

endmodule

// File: rtl/uv_prefix.sv
module uv_prefix #(
  parameter int W = 32
) (
  input  logic [W-1:0] u_i,
  input  logic [W-1:0] v_i,
  output logic [W-1:0] u_o,
  output logic [W-1:0] v_o
);

  localparam int LVLS = (W > 1) ? $clog2(W) : 1;

  for (genvar k = 0; k < LVLS; k++) begin : g_lvl
    localparam int D = 1 << k;
    logic [W-1:0] u_in, v_in, u_q, v_q;

    if (k == 0) begin : g_first
      assign u_in = u_i;
      assign v_in = v_i;
    end else begin : g_next
      assign u_in = g_lvl[k-1].u_q;
      assign v_in = g_lvl[k-1].v_q;
    end

    always_comb begin
      for (int i = 0; i < W; i++) begin
        if (i >= D) begin
          u_q[i] = v_in[i] | (u_in[i] & u_in[i-D]);
          v_q[i] = v_in[i] | (u_in[i] & v_in[i-D]);
        end else begin
          u_q[i] = u_in[i];
          v_q[i] = v_in[i];
        end
      end
    end
  end

  assign u_o = g_lvl[LVLS-1].u_q;
  assign v_o = g_lvl[LVLS-1].v_q;

  always_comb begin
    AST_UV_ORDER: assert ((v_o & ~u_o) == '0)
      else $error("prefix carry for cin=0 set without carry for cin=1"); // R3
  end

endmodule

// File: rtl/arb_adder.sv
module arb_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W-1:0] prop, bit_u, bit_v, pre_u, pre_v;
  logic [W-1:0] sum_lo, sum_hi;

  assign prop  = a_i ^ b_i;
  assign bit_u = a_i | b_i;
  assign bit_v = a_i & b_i;

  uv_prefix #(.W(W)) prefix_i (
    .u_i (bit_u),
    .v_i (bit_v),
    .u_o (pre_u),
    .v_o (pre_v)
  );

  assign sum_lo = prop ^ {pre_v[W-2:0], 1'b0};
  assign sum_hi = prop ^ {pre_u[W-2:0], 1'b1};

  assign sum_o  = cin_i ? sum_hi : sum_lo;
  assign cout_o = cin_i ? pre_u[W-1] : pre_v[W-1];

  always_comb begin
    AST_SUM_STEP: assert (sum_hi == sum_lo + {{(W-1){1'b0}}, 1'b1})
      else $error("sum+1 path does not exceed sum path by one"); // R9
    AST_ADDER_EXACT: assert ({cout_o, sum_o} ==
                             {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i})
      else $error("prefix adder disagrees with integer sum"); // R1
  end

endmodule

// File: rtl/logic_unit.sv
module logic_unit
  import alu_carry_arb_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_fn_e    fn_i,
  output logic [W-1:0] y_o
);

  always_comb begin
    case (fn_i)
      LF_AND:  y_o = a_i & b_i;
      LF_ORR:  y_o = a_i | b_i;
      LF_EOR:  y_o = a_i ^ b_i;
      default: y_o = b_i;
    endcase
  end

endmodule

// File: rtl/alu_carry_arb.sv
module alu_carry_arb
  import alu_carry_arb_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       op_i,
  input  logic             c_i,
  input  logic             v_i,
  output logic [WIDTH-1:0] res_o,
  output logic             n_o,
  output logic             z_o,
  output logic             c_o,
  output logic             v_o
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] opa, opb, sum, lres;
  logic             cin, cout, ovf;

  alu_decode decode_i (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign opa = ctrl.inv_a ? ~a_i : a_i;
  assign opb = ctrl.inv_b ? ~b_i : b_i;

  always_comb begin
    case (ctrl.cin_sel)
      CI_ONE:  cin = 1'b1;
      CI_FLAG: cin = c_i;
      default: cin = 1'b0;
    endcase
  end

  arb_adder #(.W(WIDTH)) adder_i (
    .a_i    (opa),
    .b_i    (opb),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  logic_unit #(.W(WIDTH)) logic_i (
    .a_i  (opa),
    .b_i  (opb),
    .fn_i (ctrl.lfn),
    .y_o  (lres)
  );

  assign ovf   = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);

  assign res_o = ctrl.use_logic ? lres : sum;
  assign n_o   = res_o[MSB];
  assign z_o   = ~|res_o;
  assign c_o   = ctrl.use_logic ? c_i : cout;
  assign v_o   = ctrl.use_logic ? v_i : ovf;

  always_comb begin
    if (op_i > 4'd4) begin
      AST_LOGIC_FLAGS: assert (c_o == c_i && v_o == v_i)
        else $error("logic code altered carry or overflow flag"); // R8
    end
    AST_NZ_EXCL: assert (!(n_o && z_o))
      else $error("negative and zero flags both set"); // R5
  end

endmodule

// File: tb/alu_carry_arb_tb_top.sv
module alu_carry_arb_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  op = '0;
  logic        ci = 1'b0, vi = 1'b0;
  logic [31:0] res;
  logic        n, z, c, v;

  int n_vec  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_carry_arb dut_i (
    .a_i (a), .b_i (b), .op_i (op), .c_i (ci), .v_i (vi),
    .res_o (res), .n_o (n), .z_o (z), .c_o (c), .v_o (v)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG_LIMIT && !done) begin
      done = 1'b1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual=still running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  function automatic logic [35:0] model(input logic [3:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input logic cf,
                                        input logic vf);
    logic [32:0] s;
    logic [31:0] ea, eb, r;
    logic        cc, vv;
    ea = x; eb = y; s = '0;
    case (o)
      4'd0: s = {1'b0, x} + {1'b0, y};
      4'd1: s = {1'b0, x} + {1'b0, y} + {32'd0, cf};
      4'd2: begin eb = ~y; s = {1'b0, x} + {1'b0, eb} + 33'd1; end
      4'd3: begin eb = ~y; s = {1'b0, x} + {1'b0, eb} + {32'd0, cf}; end
      4'd4: begin ea = ~x; s = {1'b0, ea} + {1'b0, y} + 33'd1; end
      default: s = '0;
    endcase
    if (o <= 4'd4) begin
      r  = s[31:0];
      cc = s[32];
      vv = (ea[31] == eb[31]) && (r[31] != ea[31]);
    end else begin
      case (o)
        4'd5:    r = x & y;
        4'd6:    r = x | y;
        4'd7:    r = x ^ y;
        4'd8:    r = x & ~y;
        4'd10:   r = ~y;
        default: r = y;
      endcase
      cc = cf;
      vv = vf;
    end
    return {r, r[31], (r == 32'd0), cc, vv};
  endfunction

  task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic cf, input logic vf, input string req);
    logic [35:0] exp, got;
    @(negedge clk);
    op = o; a = x; b = y; ci = cf; vi = vf;
    #1;
    exp = model(o, x, y, cf, vf);
    got = {res, n, z, c, v};
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h ci=%b vi=%b: actual res=%h nzcv=%b expected res=%h nzcv=%b",
               req, o, x, y, cf, vf, got[35:4], got[3:0], exp[35:4], exp[3:0]);
    end
  endtask

  task automatic t_reset_state();
    apply(4'd0, 32'd0, 32'd0, 1'b0, 1'b0, "R5 reset zero");
    apply(4'd9, 32'd0, 32'd0, 1'b1, 1'b1, "R8 reset pass");
  endtask

  task automatic t_add();
    apply(4'd0, 32'd5, 32'd7, 1'b1, 1'b0, "R1 add small");
    apply(4'd0, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, "R4 add overflow");
    apply(4'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R4 add neg overflow");
    apply(4'd1, 32'h1234_5678, 32'h0FED_CBA9, 1'b1, 1'b0, "R1 adc");
  endtask

  task automatic t_long_carry();
    apply(4'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, "R3 full ripple");
    apply(4'd1, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b0, "R3 carry-in ripple");
    apply(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R3 all ones");
    apply(4'd1, 32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 1'b0, "R3 alternating");
  endtask

  task automatic t_sub();
    apply(4'd2, 32'd10, 32'd3, 1'b0, 1'b0, "R2 sub");
    apply(4'd2, 32'd3, 32'd10, 1'b1, 1'b0, "R2 sub borrow");
    apply(4'd2, 32'h8000_0000, 32'd1, 1'b0, 1'b0, "R4 sub overflow");
    apply(4'd2, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, "R5 sub zero");
    apply(4'd3, 32'd20, 32'd5, 1'b0, 1'b0, "R2 sbc borrow-in");
    apply(4'd3, 32'd20, 32'd5, 1'b1, 1'b0, "R2 sbc no borrow");
    apply(4'd4, 32'd3, 32'd10, 1'b0, 1'b0, "R2 rsb");
    apply(4'd4, 32'd0, 32'h8000_0000, 1'b0, 1'b0, "R4 rsb");
  endtask

  task automatic t_cin_step();
    logic [31:0] r0;
    apply(4'd1, 32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b0, 1'b0, "R9 cin0");
    r0 = res;
    apply(4'd1, 32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b1, 1'b0, "R9 cin1");
    n_vec++;
    if (res !== r0 + 32'd1) begin
      n_fail++;
      $display("FAIL R9 step: actual=%h expected=%h", res, r0 + 32'd1);
    end
  endtask

  task automatic t_logic();
    apply(4'd5, 32'hF0F0_1234, 32'hFF00_FF00, 1'b1, 1'b0, "R6 and");
    apply(4'd6, 32'hF0F0_1234, 32'h0F00_0000, 1'b0, 1'b1, "R6 orr");
    apply(4'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, "R6 eor zero");
    apply(4'd8, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b0, "R6 bic");
  endtask

  task automatic t_move();
    apply(4'd9, 32'h1111_1111, 32'h8000_0000, 1'b0, 1'b1, "R7 mov");
    apply(4'd10, 32'h1111_1111, 32'hFFFF_FFFF, 1'b1, 1'b0, "R7 mvn");
    for (int k = 11; k < 16; k++)
      apply(4'(k), 32'h0000_0001, 32'h7FFF_FFFF, 1'b1, 1'b1, "R7 unused code");
  endtask

  task automatic t_flag_pass();
    for (int k = 5; k < 16; k++) begin
      apply(4'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, "R8 pass 01");
      apply(4'(k), 32'd0, 32'd0, 1'b1, 1'b0, "R8 pass 10");
    end
  endtask

  task automatic t_random();
    logic [31:0] pool [4] = '{32'd0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF};
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int o = 0; o < 5; o++)
          apply(4'(o), pool[i], pool[j], 1'(j), 1'b0, "R4 corner grid");
    for (int i = 0; i < 400; i++)
      apply(4'($urandom_range(0, 15)), $urandom, $urandom, 1'($urandom),
            1'($urandom), "R1 random");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_add();
    t_long_carry();
    t_sub();
    t_cin_step();
    t_logic();
    t_move();
    t_flag_pass();
    t_random();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule